// File: doc/BRIEF.md
# Unaligned-Tail Write Strobe Generator

This block sits in front of the write data channel of an AXI4 memory-mapped master. It takes one transfer request at a time. A request carries a byte count, encoded as length minus one. The block then forwards data beats from an internal source to the write channel and computes the byte strobe and the burst-end marker for every beat.

A transfer's byte length does not have to be a whole number of bus words. Only the final beat carries a partial strobe. That strobe is a run of ones starting at lane 0 and ending at the last valid byte, so the bytes past the end of the transfer are never written. Long transfers are cut into bursts of at most `MAX_BEATS` beats.

The start address is assumed to be aligned to the bus width. Address issue, response tracking and data buffering belong to neighbouring blocks.

Top module: `wstrb_tail_gen`

## Requirements
- R1: While `rst_ni` is low and right after its release, `wvalid_o` is 0 and `req_ready_o` is 1. An asynchronous reset in the middle of a transfer abandons that transfer.
- R2: Every beat except the final one of a transfer drives `wstrb_o` as all ones.
- R3: On the final beat, `wstrb_o` bit i is 1 exactly when i <= (len_m1 mod bytes-per-beat). The result is a thermometer code anchored at lane 0. For example, len_m1 = 1 on an 8-byte bus gives 0x03.
- R4: A transfer carries (len_m1 >> log2(bytes-per-beat)) + 1 beats. After that many handshakes the block returns to idle.
- R5: `wlast_o` is 1 on every MAX_BEATS-th beat counted from the start of the transfer, and on the final beat. It is 0 on every other beat.
- R6: `req_ready_o` is 0 from the cycle after a request is accepted until the final beat's handshake. It is 1 in the cycle after that handshake.
- R7: While a transfer is active, `wvalid_o` follows `src_valid_i`, `src_ready_o` follows `wready_i`, and `wdata_o` equals `src_data_i`. While idle, both `wvalid_o` and `src_ready_o` stay 0 whatever the inputs do.
- R8: While `wvalid_o` is 1 and `wready_i` is 0, `wstrb_o` and `wlast_o` keep their values into the next cycle.
- R9: When the final beat is also a burst boundary, that beat carries a single `wlast_o` together with the partial strobe. The next request is then accepted normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Transfer request valid |
| req_ready_o | output | 1 | Block idle, request accepted |
| req_len_m1_i | input | LEN_W | Transfer byte length minus one |
| src_valid_i | input | 1 | Source beat valid |
| src_ready_o | output | 1 | Source beat taken |
| src_data_i | input | DATA_W | Source beat data |
| wvalid_o | output | 1 | Write data valid |
| wready_i | input | 1 | Write data ready |
| wdata_o | output | DATA_W | Write data |
| wstrb_o | output | DATA_W/8 | Write byte strobe |
| wlast_o | output | 1 | Last beat of burst |

## Verification
Two things can land on the same beat: the burst-boundary marker and the end of the transfer with its partial strobe. The bench forces this with lengths whose beat count is an exact multiple of MAX_BEATS, once with a full final word and once with a partial one. On that beat it requires exactly one `wlast_o` carrying the partial strobe, and it requires the next request to be accepted in the following cycle. Stalls on both the source side and the write side are mixed in, so the coinciding beat is also seen held under back-pressure.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} run_st_e;
endpackage

// File: rtl/wsg_beat_ctrl.sv
module wsg_beat_ctrl
  import wsg_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int OFS_W     = 3,
  parameter int MAX_BEATS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_m1_i,
  input  logic             beat_i,
  output logic             busy_o,
  output logic             final_o,
  output logic             burst_end_o,
  output logic [OFS_W-1:0] tail_o
);
  localparam int CNT_W   = LEN_W - OFS_W;
  localparam int BURST_W = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1;

  run_st_e            st_q;
  logic [CNT_W-1:0]   left_q;   // beats remaining after the current one
  logic [BURST_W-1:0] bcnt_q;   // position inside current burst
  logic [OFS_W-1:0]   tail_q;

  assign busy_o      = (st_q == ST_RUN);
  assign final_o     = busy_o && (left_q == '0);
  assign burst_end_o = (bcnt_q == BURST_W'(MAX_BEATS - 1));
  assign tail_o      = tail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      left_q <= '0;
      bcnt_q <= '0;
      tail_q <= '0;
    end else if (start_i && !busy_o) begin
      st_q   <= ST_RUN;
      left_q <= len_m1_i[LEN_W-1:OFS_W];
      bcnt_q <= '0;
      tail_q <= len_m1_i[OFS_W-1:0];
    end else if (beat_i && busy_o) begin
      if (final_o) begin
        st_q <= ST_IDLE;
      end else begin
        left_q <= left_q - CNT_W'(1);
      end
      bcnt_q <= burst_end_o ? '0 : bcnt_q + BURST_W'(1);
    end
  end
endmodule

// File: rtl/wsg_strb_enc.sv
module wsg_strb_enc #(
  parameter int STRB_W = 8,
  parameter int OFS_W  = 3
) (
  input  logic              final_i,
  input  logic [OFS_W-1:0]  tail_i,
  output logic [STRB_W-1:0] strb_o
);
  // lane i enabled unless on final beat and beyond tail byte
  for (genvar i = 0; i < STRB_W; i++) begin : g_lane
    assign strb_o[i] = ~final_i | (OFS_W'(i) <= tail_i);
  end
endmodule

// File: rtl/wstrb_tail_gen.sv
module wstrb_tail_gen #(
  parameter int DATA_W    = 64,
  parameter int LEN_W     = 16,
  parameter int MAX_BEATS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [LEN_W-1:0]    req_len_m1_i,
  input  logic                src_valid_i,
  output logic                src_ready_o,
  input  logic [DATA_W-1:0]   src_data_i,
  output logic                wvalid_o,
  input  logic                wready_i,
  output logic [DATA_W-1:0]   wdata_o,
  output logic [DATA_W/8-1:0] wstrb_o,
  output logic                wlast_o
);
  localparam int STRB_W = DATA_W / 8;
  localparam int OFS_W  = $clog2(STRB_W);

  logic             busy, fin, burst_end, beat;
  logic [OFS_W-1:0] tail;

  assign req_ready_o = ~busy;
  assign wvalid_o    = busy & src_valid_i;
  assign src_ready_o = busy & wready_i;
  assign wdata_o     = src_data_i;
  assign beat        = wvalid_o & wready_i;
  assign wlast_o     = busy & (fin | burst_end);

  wsg_beat_ctrl #(
    .LEN_W(LEN_W), .OFS_W(OFS_W), .MAX_BEATS(MAX_BEATS)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(req_valid_i), .len_m1_i(req_len_m1_i),
    .beat_i(beat), .busy_o(busy), .final_o(fin),
    .burst_end_o(burst_end), .tail_o(tail)
  );

  wsg_strb_enc #(
    .STRB_W(STRB_W), .OFS_W(OFS_W)
  ) u_enc (
    .final_i(fin), .tail_i(tail), .strb_o(wstrb_o)
  );
endmodule

// File: rtl/wstrb_tail_gen_chk.sv
module wstrb_tail_gen_chk #(
  parameter int DATA_W    = 64,
  parameter int MAX_BEATS = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_valid_i,
  input logic                req_ready_o,
  input logic                wvalid_o,
  input logic                wready_i,
  input logic [DATA_W/8-1:0] wstrb_o,
  input logic                wlast_o
);
  localparam int CW = $clog2(MAX_BEATS + 1) + 1;
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_cnt <= '0;
    else if (wvalid_o && wready_i) run_cnt <= wlast_o ? '0 : run_cnt + CW'(1);
  end

  assert_no_wvalid_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !wvalid_o);

  assert_full_strb_mid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wvalid_o && !wlast_o) |-> (&wstrb_o));

  assert_thermo_strb_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wvalid_o |-> (wstrb_o[0] && (((wstrb_o + 1'b1) & wstrb_o) == '0)));

  assert_burst_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wvalid_o && wready_i && run_cnt == CW'(MAX_BEATS - 1)) |-> wlast_o);

  assert_busy_after_accept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  assert_hold_on_stall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wvalid_o && !wready_i) |=> ($stable(wstrb_o) && $stable(wlast_o)));
endmodule

bind wstrb_tail_gen wstrb_tail_gen_chk #(
  .DATA_W(DATA_W), .MAX_BEATS(MAX_BEATS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o), .wvalid_o(wvalid_o), .wready_i(wready_i),
  .wstrb_o(wstrb_o), .wlast_o(wlast_o)
);

// File: tb/wstrb_tail_gen_bench.sv
`timescale 1ns/1ps
module wstrb_tail_gen_bench;
  localparam int DATA_W = 64;
  localparam int LEN_W  = 16;
  localparam int MB     = 4;
  localparam int NB     = DATA_W / 8;
  localparam int NVEC   = 10;

  // {stall_mode[3:0], len_m1[15:0]}; mode bit0 = wready gaps, bit1 = source gaps
  localparam logic [19:0] VEC [NVEC] = '{
    {4'h0, 16'd0},  {4'h1, 16'd7},  {4'h2, 16'd8},  {4'h3, 16'd31},
    {4'h1, 16'd29}, {4'h0, 16'd33}, {4'h3, 16'd63}, {4'h2, 16'd1},
    {4'h3, 16'd70}, {4'h0, 16'd61}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid = 1'b0, src_valid = 1'b0, wready = 1'b0;
  logic [LEN_W-1:0] req_len = '0;
  logic [DATA_W-1:0] src_data = '0;
  logic req_ready, src_ready, wvalid, wlast;
  logic [DATA_W-1:0] wdata;
  logic [NB-1:0] wstrb;
  int n_chk = 0, n_err = 0, cyc = 0;

  always #2 clk = ~clk;

  wstrb_tail_gen #(.DATA_W(DATA_W), .LEN_W(LEN_W), .MAX_BEATS(MB)) u_wstrb_tail_gen (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_len_m1_i(req_len), .src_valid_i(src_valid), .src_ready_o(src_ready),
    .src_data_i(src_data), .wvalid_o(wvalid), .wready_i(wready), .wdata_o(wdata),
    .wstrb_o(wstrb), .wlast_o(wlast));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NB-1:0] exp_strb(input int len, input bit fin);
    logic [NB-1:0] r;
    for (int i = 0; i < NB; i++) r[i] = !fin || (i <= (len % NB));
    return r;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  task automatic issue(input int len);
    @(negedge clk);
    req_valid = 1'b1; req_len = LEN_W'(len);
    #1 chk(req_ready, "R6 idle accepts", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_xfer(input int len, input logic [3:0] mode);
    int beats = (len / NB) + 1;
    int k = 0, c = 0;
    bit prev_stall = 0;
    logic [NB-1:0] s_strb = '0;
    logic s_last = 1'b0;
    issue(len);
    while (k < beats && c < 2000) begin
      if (c > 0) @(negedge clk);
      src_valid = !(mode[1] && (c % 3 == 2));
      wready    = !(mode[0] && (c % 2 == 1));
      src_data  = {16'(len), 16'hA5C3, 32'(k)};
      #1;
      chk(!req_ready, "R6 busy during transfer", req_ready, 0);
      chk(wvalid == src_valid, "R7 valid follows source", wvalid, src_valid);
      chk(src_ready == wready, "R7 ready follows sink", src_ready, wready);
      if (prev_stall) begin
        chk(wstrb == s_strb, "R8 strobe held", wstrb, s_strb);
        chk(wlast == s_last, "R8 last held", wlast, s_last);
      end
      prev_stall = wvalid && !wready;
      s_strb = wstrb; s_last = wlast;
      if (wvalid && wready) begin
        bit fin = (k == beats - 1);
        bit el  = fin || (k % MB == MB - 1);
        chk(wdata == src_data, "R7 data pass", wdata, src_data);
        chk(wstrb == exp_strb(len, fin), fin ? "R3 tail strobe" : "R2 full strobe",
            wstrb, exp_strb(len, fin));
        chk(wlast == el, (fin && (beats % MB == 0)) ? "R9 coincident last" : "R5 burst last",
            wlast, el);
        k++;
      end
      c++;
    end
    chk(k == beats, "R4 beat count", k, beats);
    @(negedge clk);
    src_valid = 1'b1; wready = 1'b1;
    #1 chk(req_ready, "R6 ready after final", req_ready, 1);
    chk(!wvalid && !src_ready, "R4 idle after final", wvalid, 0);
    src_valid = 1'b0; wready = 1'b0;
  endtask

  initial begin
    // R1 reset state
    #1 chk(!wvalid && req_ready, "R1 in reset", {wvalid, req_ready}, 1);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    #1 chk(!wvalid && req_ready, "R1 after release", {wvalid, req_ready}, 1);
    // R7 idle: no beat passes
    src_valid = 1'b1; wready = 1'b1;
    #1 chk(!wvalid && !src_ready, "R7 idle blocks", {wvalid, src_ready}, 0);
    src_valid = 1'b0; wready = 1'b0;

    for (int v = 0; v < NVEC; v++) run_xfer(int'(VEC[v][15:0]), VEC[v][19:16]);

    // R6 request held during transfer is not taken
    issue(15);
    req_valid = 1'b1; req_len = 16'd0;
    src_valid = 1'b1; wready = 1'b1;
    #1 chk(!req_ready, "R6 second request blocked", req_ready, 0);
    @(negedge clk);
    #1 chk(!req_ready && wlast && wstrb == 8'hFF, "R6 final beat busy", req_ready, 0);
    @(negedge clk);
    #1 chk(req_ready, "R6 reaccept", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    #1 chk(wvalid && wlast && wstrb == 8'h01, "R3 queued request single byte", wstrb, 1);
    @(negedge clk);
    src_valid = 1'b0; wready = 1'b0;

    // R1 reset mid transfer
    issue(63);
    src_valid = 1'b1; wready = 1'b1;
    repeat (2) @(negedge clk);
    rst_ni = 1'b0;
    #1 chk(!wvalid && req_ready, "R1 mid-transfer reset", {wvalid, req_ready}, 1);
    @(negedge clk);
    rst_ni = 1'b1; src_valid = 1'b0; wready = 1'b0;
    run_xfer(1, 4'h0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule